// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up before normal traffic begins. A single start pulse makes it compute the mode-register value from the configured CAS-latency code, clock speed and bus width. A nonzero override byte replaces that computed value. The block holds refresh off and waits out a stabilisation delay. It then plays a fixed stream of command slots onto a two-bit command output, and each slot is marked by a one-cycle valid strobe.

The whole pass runs twice back to back: the stabilisation wait, one precharge, eight auto-refreshes and a mode-register set, each command followed by a NOP slot. The block then raises done and enables auto-refresh. The computed mode data is latched at start and held on its own output, so the mode-register set command can pick it up. Refresh scheduling, the data path and normal read and write traffic belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied and afterwards until a start, `cmd` is 0 (NOP), `cmd_valid` is 0, `refresh_en` is 0, `done` is 0 and `mode_data` is 0.
- R2: With `mode_override` zero, the latched `mode_data` is 0x40 for CAS 2 and 0x60 for CAS 3 when `width_32`=1, and half of that (0x20 or 0x30) when `width_32`=0.
- R3: The CAS code is decoded per speed. With `speed_100`=1, code 0 is CAS 2 and codes 1 to 3 are CAS 3. With `speed_100`=0, code 1 is CAS 2 and codes 0, 2 and 3 are CAS 3.
- R4: A nonzero `mode_override` is latched into `mode_data` unchanged, whatever the CAS, speed and width inputs are.
- R5: Each pass strobes 20 slots. Even slots carry, in order, precharge (3), eight auto-refreshes (2) and mode-register set (1). Every odd slot carries NOP (0). `cmd` is 0 whenever `cmd_valid` is low.
- R6: `cmd_valid` is high for exactly one cycle per slot. Consecutive slots are separated by GAP_CYCLES idle cycles, so strobes are GAP_CYCLES+1 cycles apart.
- R7: Every pass starts with a wait of WAIT_CYCLES cycles. The first strobe of a pass appears WAIT_CYCLES+1 cycles after the clock edge that sampled start, or after the end of the previous pass's last gap.
- R8: Two full passes run. `done` rises in the cycle after the last gap of the second pass: 2·(WAIT_CYCLES+20·(GAP_CYCLES+1))+1 cycles after the start edge.
- R9: `refresh_en` is 0 from start until the sequence ends, and it rises together with `done`.
- R10: A start pulse while the sequence runs has no effect on the command timing, the codes or `mode_data`.
- R11: `done` and `refresh_en` stay high until reset or the next start. A start after done clears both and reruns the full sequence.
- R12: `mode_data` holds its latched value for the whole sequence, even if the configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches the sequence from idle or done |
| cas_code | input | 2 | CAS-latency code, decoded per speed |
| speed_100 | input | 1 | 1 = 100 MHz clock, 0 = 50 MHz |
| width_32 | input | 1 | 1 = 32-bit bus, 0 = 16-bit |
| mode_override | input | 8 | Nonzero value replaces the computed mode data |
| cmd | output | 2 | Command code: 0 NOP, 1 mode set, 2 auto-refresh, 3 precharge |
| cmd_valid | output | 1 | One-cycle strobe marking a command slot |
| refresh_en | output | 1 | Auto-refresh enable, high only after the sequence |
| mode_data | output | 8 | Latched mode-register data |
| done | output | 1 | Sequence complete |

## Verification
The hardest condition to reach from the ports is a start pulse that lands in the middle of a running sequence, together with configuration inputs that change during the run. The bench pulses start again partway through the first pass, and it scrambles the CAS, speed, width and override inputs during the run. It then checks that every strobe still lands on its arithmetically predicted cycle with its predicted code, and that `mode_data` never moves. All sixteen CAS, speed and width combinations and several override values are swept, each as a restart from the done state of the run before.

// File: rtl/sdram_init_pkg.sv
// Package: shared command encoding and sequencer state type.
// Assumes: command codes are fixed by the SDRAM controller's decoder.
package sdram_init_pkg;
    typedef enum logic [1:0] {
        CMD_NOP       = 2'd0,
        CMD_MODE_SET  = 2'd1,
        CMD_AUTO_REF  = 2'd2,
        CMD_PRECHARGE = 2'd3
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SLOT,
        ST_GAP,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/sdram_mode_calc.sv
// Module: combinational mode-register data calculation.
// Derives the CAS latency from the code and the clock speed, picks the
// 32-bit value and halves it for a 16-bit bus. A nonzero override wins.
// Assumes: the caller latches the result when the sequence starts.
module sdram_mode_calc #(
    parameter int MODE_W = 8
) (
    input  logic [1:0]        cas_code,
    input  logic              speed_100,
    input  logic              width_32,
    input  logic [MODE_W-1:0] override,
    output logic [MODE_W-1:0] mode
);
    logic              cas3;
    logic [MODE_W-1:0] base;

    // Decode CAS latency and form the mode value
    always_comb begin
        cas3 = speed_100 ? (cas_code != 2'd0) : (cas_code != 2'd1);
        base = cas3 ? MODE_W'(8'h60) : MODE_W'(8'h40);
        if (override != '0)
            mode = override;
        else if (width_32)
            mode = base;
        else
            mode = base >> 1;
    end
endmodule

// File: rtl/sdram_cmd_table.sv
// Module: maps a slot index within a pass to its command code.
// Even slots: precharge, N_REFRESH auto-refreshes, mode set; odd slots NOP.
// Assumes: slot is below 2*(N_REFRESH+2).
module sdram_cmd_table
    import sdram_init_pkg::*;
#(
    parameter int N_REFRESH = 8,
    parameter int SLOT_W    = 5
) (
    input  logic [SLOT_W-1:0] slot,
    output sdram_cmd_e        code
);
    logic [SLOT_W-1:0] idx;

    // Select the code for the command position of this slot
    always_comb begin
        idx = slot >> 1;
        if (slot[0])
            code = CMD_NOP;
        else if (idx == '0)
            code = CMD_PRECHARGE;
        else if (idx == SLOT_W'(N_REFRESH + 1))
            code = CMD_MODE_SET;
        else
            code = CMD_AUTO_REF;
    end
endmodule

// File: rtl/sdram_init_timer.sv
// Module: phase counter, cleared at the end of each wait or gap phase.
// Assumes: the width holds the longest phase length.
module sdram_init_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    // Count cycles within the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the SDRAM power-up initialization sequencer.
// Runs N_PASSES passes, each a WAIT_CYCLES wait followed by the slot stream,
// with GAP_CYCLES idle cycles after every slot. Refresh is held off until done.
// Assumes: GAP_CYCLES >= 1, WAIT_CYCLES >= 1, synchronous active-low reset.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int WAIT_CYCLES = 10000,
    parameter int GAP_CYCLES  = 5,
    parameter int N_REFRESH   = 8,
    parameter int N_PASSES    = 2,
    parameter int MODE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cas_code,
    input  logic              speed_100,
    input  logic              width_32,
    input  logic [MODE_W-1:0] mode_override,
    output logic [1:0]        cmd,
    output logic              cmd_valid,
    output logic              refresh_en,
    output logic [MODE_W-1:0] mode_data,
    output logic              done
);
    localparam int SLOTS  = 2 * (N_REFRESH + 2);
    localparam int SLOT_W = $clog2(SLOTS + 1);
    localparam int PASS_W = $clog2(N_PASSES + 1);
    localparam int LONGEST = (WAIT_CYCLES > GAP_CYCLES) ? WAIT_CYCLES : GAP_CYCLES;
    localparam int CNT_W  = $clog2(LONGEST + 1);

    seq_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic [PASS_W-1:0] pass;
    logic [CNT_W-1:0]  cnt;
    logic [MODE_W-1:0] mode_next;
    sdram_cmd_e        slot_code;
    logic              wait_end, gap_end, phase_clear;

    sdram_mode_calc #(.MODE_W(MODE_W)) i_calc (
        .cas_code (cas_code),
        .speed_100(speed_100),
        .width_32 (width_32),
        .override (mode_override),
        .mode     (mode_next)
    );

    sdram_cmd_table #(.N_REFRESH(N_REFRESH), .SLOT_W(SLOT_W)) i_table (
        .slot(slot),
        .code(slot_code)
    );

    sdram_init_timer #(.CNT_W(CNT_W)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(phase_clear),
        .cnt  (cnt)
    );

    // Detect the last cycle of a wait or gap phase
    always_comb begin
        wait_end    = (state == ST_WAIT) && (cnt == CNT_W'(WAIT_CYCLES - 1));
        gap_end     = (state == ST_GAP)  && (cnt == CNT_W'(GAP_CYCLES - 1));
        phase_clear = wait_end || gap_end || (state == ST_IDLE) ||
                      (state == ST_SLOT) || (state == ST_DONE);
    end

    // Sequencer state, slot and pass tracking, mode latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            slot      <= '0;
            pass      <= '0;
            mode_data <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        mode_data <= mode_next;
                        slot      <= '0;
                        pass      <= '0;
                        state     <= ST_WAIT;
                    end
                end
                ST_WAIT: if (wait_end) state <= ST_SLOT;
                ST_SLOT: state <= ST_GAP;
                ST_GAP: begin
                    if (gap_end) begin
                        if (slot == SLOT_W'(SLOTS - 1)) begin
                            slot <= '0;
                            if (pass == PASS_W'(N_PASSES - 1)) begin
                                state <= ST_DONE;
                            end else begin
                                pass  <= pass + 1'b1;
                                state <= ST_WAIT;
                            end
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= ST_SLOT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive command outputs and completion flags from the state
    always_comb begin
        cmd_valid  = (state == ST_SLOT);
        cmd        = cmd_valid ? slot_code : CMD_NOP;
        done       = (state == ST_DONE);
        refresh_en = (state == ST_DONE);
    end

    // ---------------- assertions ----------------
    logic              busy;
    logic [CNT_W-1:0]  since_strobe;
    logic              seen_strobe;

    assign busy = (state == ST_WAIT) || (state == ST_SLOT) || (state == ST_GAP);

    // Track idle cycles since the last strobe within a run
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            since_strobe <= '0;
            seen_strobe  <= 1'b0;
        end else if (cmd_valid) begin
            since_strobe <= '0;
            seen_strobe  <= 1'b1;
        end else if (since_strobe != '1) begin
            since_strobe <= since_strobe + 1'b1;
        end
    end

    // R6
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen_strobe) |-> (since_strobe >= CNT_W'(GAP_CYCLES)));

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5
    idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd == CMD_NOP));

    // R9
    refresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !refresh_en);

    // R12
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_data));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT = 12;
    localparam int GAP  = 5;
    localparam int PER  = WAIT + 20 * (GAP + 1);
    localparam int DONE_CYC = 2 * PER + 1;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       start = 0;
    logic [1:0] cas_code = 0;
    logic       speed_100 = 0;
    logic       width_32 = 0;
    logic [7:0] mode_override = 0;
    logic [1:0] cmd;
    logic       cmd_valid, refresh_en, done;
    logic [7:0] mode_data;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_init_seq #(.WAIT_CYCLES(WAIT), .GAP_CYCLES(GAP)) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cas_code(cas_code),
        .speed_100(speed_100), .width_32(width_32), .mode_override(mode_override),
        .cmd(cmd), .cmd_valid(cmd_valid), .refresh_en(refresh_en),
        .mode_data(mode_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_mode(input int cas, input int spd, input int w, input int ovr);
        int c3;
        int v;
        if (ovr != 0) return ovr;
        c3 = spd ? (cas != 0) : (cas != 1);
        v = c3 ? 'h60 : 'h40;
        return w ? v : v / 2;
    endfunction

    // Run one complete sequence and compare every cycle against the schedule
    task automatic run_seq(input int cas, input int spd, input int w, input int ovr,
                           input bit disturb);
        int em;
        int bad_cmd;
        int bad_flag;
        int bad_mode;
        int first_bad;
        int nstrobe;
        em = exp_mode(cas, spd, w, ovr);
        cas_code = 2'(cas); speed_100 = spd[0]; width_32 = w[0]; mode_override = 8'(ovr);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        // R11: start from done clears done and refresh
        check(!done && !refresh_en, "R11 clear on start", {done, refresh_en}, 0);
        // R2 R3 R4
        check(mode_data == 8'(em), ovr != 0 ? "R4 override" : "R2/R3 mode", mode_data, em);
        bad_cmd = 0; bad_flag = 0; bad_mode = 0; nstrobe = 0; first_bad = -1;
        for (int cyc = 1; cyc <= DONE_CYC + 3; cyc++) begin
            int off;
            int j;
            int k;
            bit es;
            int ec;
            es = 0; ec = 0;
            if (cyc < DONE_CYC) begin
                off = (cyc - 1) % PER;
                if (off >= WAIT && ((off - WAIT) % (GAP + 1)) == 0) begin
                    j = (off - WAIT) / (GAP + 1);
                    k = j / 2;
                    es = 1;
                    ec = (j % 2) ? 0 : (k == 0) ? 3 : (k == 9) ? 1 : 2;
                end
            end
            if (cmd_valid !== es || cmd !== 2'(ec)) begin
                bad_cmd++;
                if (first_bad < 0) first_bad = cyc;
            end
            if (cmd_valid) nstrobe++;
            if ((cyc < DONE_CYC) ? (done || refresh_en) : (!done || !refresh_en)) bad_flag++;
            if (cyc < DONE_CYC && mode_data != 8'(em)) bad_mode++;
            if (disturb) begin
                if (cyc == 40) begin
                    start = 1; cas_code = ~cas_code; speed_100 = ~speed_100;
                    width_32 = ~width_32; mode_override = 8'h5A;
                end
                if (cyc == 41) start = 0;
            end
            @(negedge clk);
        end
        // R5 R6 R7: codes and strobe cycles per slot
        check(bad_cmd == 0, disturb ? "R10 schedule with mid-run start" : "R5/R6/R7 schedule",
              first_bad, -1);
        check(nstrobe == 40, "R5 strobe count", nstrobe, 40);
        // R8 R9: done and refresh_en timing
        check(bad_flag == 0, "R8/R9 done and refresh timing", bad_flag, 0);
        // R12 (R10 when disturbed)
        check(bad_mode == 0, "R12 mode stable", bad_mode, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cmd == 0 && !cmd_valid && !refresh_en && !done && mode_data == 0,
              "R1 reset state", {cmd, cmd_valid, refresh_en, done}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check(cmd == 0 && !cmd_valid && !refresh_en && !done, "R1 idle after reset",
              {cmd, cmd_valid, refresh_en, done}, 0);
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 4; c++)
                    run_seq(c, s, w, 0, 0);
        run_seq(0, 1, 1, 8'h01, 0);
        run_seq(3, 0, 0, 8'hFF, 0);
        run_seq(1, 1, 0, 8'h33, 0);
        run_seq(2, 0, 1, 0, 1);
        run_seq(1, 0, 1, 8'h77, 1);
        // R11: done held with no start
        repeat (30) @(negedge clk);
        check(done && refresh_en, "R11 done held", {done, refresh_en}, 3);
        // R1: reset mid-run returns to idle
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(cmd == 0 && !cmd_valid && !refresh_en && !done && mode_data == 0,
              "R1 reset mid-run", {cmd, cmd_valid, refresh_en, done}, 0);
        rst_n = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule